// File: doc/BRIEF.md
# Serial Port Baud Rate Generator

This block derives the timing strobes for a classic four-mode serial port from the system clock. In the synchronous shift mode it issues one shift strobe every twelve clocks. In the three asynchronous modes it issues a sixteen-times oversampling strobe, which the transmitter and receiver count so that sixteen strobes make one bit period.

In the fixed-rate asynchronous mode the strobe comes from a constant division of the clock, and a doubling control halves that division. The two variable-rate modes take their strobe from one of two overflow sources. The first is an 8-bit up-counting timer that reloads itself and advances once every twelve clocks. The second is a 16-bit up-counting timer that reloads itself and advances on every clock. The doubling control acts on the 8-bit source only. The 16-bit source is always halved.

A timer that is not selected stays loaded with its reload value. When it is selected, its first period therefore starts from that value.

Top module: `baud_gen`

## Requirements
- R1: While rst_ni is low, shift_tick_o and tick16_o are both low.
- R2: With mode_i = 0, shift_tick_o pulses once every 12 clocks and tick16_o stays low.
- R3: With mode_i = 1, 2 or 3, shift_tick_o stays low.
- R4: With mode_i = 2, tick16_o pulses every 4 clocks when dbl_i = 0 and every 2 clocks when dbl_i = 1.
- R5: With mode_i = 1 or 3, alt_timer_i = 0 and dbl_i = 1, tick16_o pulses every 12*(256 - reload8_i) clocks. The 8-bit timer advances on every twelfth clock, counts up to 0xFF, then reloads.
- R6: With mode_i = 1 or 3, alt_timer_i = 0 and dbl_i = 0, tick16_o pulses every 24*(256 - reload8_i) clocks.
- R7: With mode_i = 1 or 3 and alt_timer_i = 1, tick16_o pulses every 2*(65536 - reload16_i) clocks, whatever the value of dbl_i.
- R8: Mode 3 produces the same tick16_o spacing as mode 1 for the same settings.
- R9: A new reload8_i value is used from the next reload on. Once a full period has passed, the spacing follows the new value.
- R10: Every pulse on shift_tick_o and on tick16_o lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Serial mode, 0 to 3 |
| dbl_i | input | 1 | Rate doubling control |
| reload8_i | input | 8 | Reload value of the 8-bit timer |
| reload16_i | input | 16 | Reload value of the 16-bit timer |
| alt_timer_i | input | 1 | Selects the 16-bit timer for modes 1 and 3 |
| shift_tick_o | output | 1 | Mode 0 shift strobe |
| tick16_o | output | 1 | Sixteen-times oversampling strobe |

## Verification
The spacing between strobes is measured under several settings:
- **Fixed divisions.** Mode 0 and mode 2 are run with both doubling settings. This separates the divide-by-12 path from the divide-by-2 and divide-by-4 paths.
- **8-bit timer reloads.** Values 0xFF, 0xF0 and 0x00 are used, with doubling on and off. The smallest and largest counts expose off-by-one errors in the reload and in the twelve-clock prescaler. Swapping the doubling choice shows up as a spacing twice or half the expected one.
- **16-bit timer reloads.** Values 0xFFFF and 0xFF00 are used with doubling toggled. This shows that doubling does not reach this path.
- **Selection and timing of changes.** Mode 3 is compared against mode 1, a reload value is changed while the timer runs, and single-cycle pulse width is checked. Together these catch wrong mode decoding and stretched strobes.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'd0,
    MODE_VAR8   = 2'd1,
    MODE_FIXED9 = 2'd2,
    MODE_VAR9   = 2'd3
  } ser_mode_e;

  localparam int unsigned DEF_PRESCALE = 12;
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pulse_o
);
  generate
    if (DIV > 1) begin : g_div
      localparam int unsigned W = $clog2(DIV);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    cnt_q <= '0;
        else if (cnt_q == W'(DIV - 1))  cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
      end
      assign pulse_o = (cnt_q == W'(DIV - 1));
    end else begin : g_pass
      assign pulse_o = rst_ni;
    end
  endgenerate
endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         at_top;

  assign at_top = (cnt_q == {W{1'b1}});

  // idle timer is parked at the reload value so a fresh period starts on selection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= reload_i;
    else if (en_i)    cnt_q <= at_top ? reload_i : cnt_q + 1'b1;
  end

  assign ovf_o = run_i & en_i & at_top;
endmodule

// File: rtl/baud_halver.sv
module baud_halver (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic bypass_i,
  output logic pulse_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ph_q <= 1'b0;
    else if (pulse_i)  ph_q <= ~ph_q;
  end

  assign pulse_o = pulse_i & (bypass_i | ph_q);
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int unsigned PRESCALE = DEF_PRESCALE,
  parameter int unsigned T8_W     = 8,
  parameter int unsigned T16_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             dbl_i,
  input  logic [T8_W-1:0]  reload8_i,
  input  logic [T16_W-1:0] reload16_i,
  input  logic             alt_timer_i,
  output logic             shift_tick_o,
  output logic             tick16_o
);
  ser_mode_e mode;
  logic      var_mode;
  logic      pre_pulse;
  logic      ovf8, ovf16;
  logic      t8_tick, t16_tick;
  logic      fix_half, fix_tick;

  assign mode     = ser_mode_e'(mode_i);
  assign var_mode = (mode == MODE_VAR8) || (mode == MODE_VAR9);

  baud_prescale #(.DIV(PRESCALE)) u_pre (
    .clk_i, .rst_ni, .pulse_o(pre_pulse)
  );

  baud_reload_timer #(.W(T8_W)) u_t8 (
    .clk_i, .rst_ni,
    .run_i   (var_mode & ~alt_timer_i),
    .en_i    (pre_pulse),
    .reload_i(reload8_i),
    .ovf_o   (ovf8)
  );

  baud_reload_timer #(.W(T16_W)) u_t16 (
    .clk_i, .rst_ni,
    .run_i   (var_mode & alt_timer_i),
    .en_i    (1'b1),
    .reload_i(reload16_i),
    .ovf_o   (ovf16)
  );

  // 8-bit overflow halved unless doubled
  baud_halver u_h8 (
    .clk_i, .rst_ni, .pulse_i(ovf8), .bypass_i(dbl_i), .pulse_o(t8_tick)
  );

  // 16-bit overflow always halved
  baud_halver u_h16 (
    .clk_i, .rst_ni, .pulse_i(ovf16), .bypass_i(1'b0), .pulse_o(t16_tick)
  );

  // fixed path: clk/2, then clk/4 unless doubled
  baud_halver u_hf0 (
    .clk_i, .rst_ni, .pulse_i(rst_ni), .bypass_i(1'b0), .pulse_o(fix_half)
  );
  baud_halver u_hf1 (
    .clk_i, .rst_ni, .pulse_i(fix_half), .bypass_i(dbl_i), .pulse_o(fix_tick)
  );

  always_comb begin
    shift_tick_o = 1'b0;
    tick16_o     = 1'b0;
    unique case (mode)
      MODE_SHIFT:            shift_tick_o = pre_pulse;
      MODE_FIXED9:           tick16_o     = fix_tick;
      MODE_VAR8, MODE_VAR9:  tick16_o     = alt_timer_i ? t16_tick : t8_tick;
      default: ;
    endcase
  end
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       dbl_i,
  input logic       shift_tick_o,
  input logic       tick16_o
);
  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (!shift_tick_o && !tick16_o));

  a_r2_no_tick16_mode0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |-> !tick16_o);

  a_r3_no_shift_async: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd0) |-> !shift_tick_o);

  a_r4_fast_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick16_o, 2) && $past(mode_i == 2'd2 && dbl_i, 2) &&
     $past(mode_i == 2'd2 && dbl_i) && mode_i == 2'd2 && dbl_i) |-> tick16_o);

  a_r10_shift_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_tick_o |=> !shift_tick_o);

  a_r10_tick16_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick16_o |=> !tick16_o);
endmodule

bind baud_gen baud_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .dbl_i       (dbl_i),
  .shift_tick_o(shift_tick_o),
  .tick16_o    (tick16_o)
);

// File: tb/baud_gen_tb.sv
module baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dbl = 1'b0;
  logic [7:0]  r8 = 8'h00;
  logic [15:0] r16 = 16'h0000;
  logic        alt = 1'b0;
  logic        shift_tick, tick16;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  baud_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dbl_i(dbl),
    .reload8_i(r8), .reload16_i(r16), .alt_timer_i(alt),
    .shift_tick_o(shift_tick), .tick16_o(tick16)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic d, input logic [7:0] a,
                         input logic [15:0] b, input logic s);
    @(negedge clk);
    mode = m; dbl = d; r8 = a; r16 = b; alt = s;
  endtask

  task automatic next_gap(input bit use16, output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!(use16 ? tick16 : shift_tick) && gap < 140000);
  endtask

  task automatic count_ticks(input bit use16, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (use16 ? tick16 : shift_tick) cnt++;
    end
  endtask

  // settle two strobes, then check two gaps and the pulse width
  task automatic measure(input string req, input bit use16, input int exp);
    int g;
    next_gap(use16, g);
    next_gap(use16, g);
    for (int k = 0; k < 2; k++) begin
      next_gap(use16, g);
      check(req, g, exp);
    end
    @(negedge clk);
    check("R10", int'(use16 ? tick16 : shift_tick), 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R1", int'(shift_tick | tick16), 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_mode0();
    int c;
    set_cfg(2'd0, 1'b0, 8'h00, 16'h0000, 1'b0);
    measure("R2", 1'b0, 12);
    count_ticks(1'b1, 100, c);
    check("R2", c, 0);
  endtask

  task automatic t_mode2();
    int c;
    set_cfg(2'd2, 1'b0, 8'h00, 16'h0000, 1'b0);
    measure("R4", 1'b1, 4);
    count_ticks(1'b0, 60, c);
    check("R3", c, 0);
    set_cfg(2'd2, 1'b1, 8'h00, 16'h0000, 1'b0);
    measure("R4", 1'b1, 2);
  endtask

  task automatic t_timer8();
    int c;
    set_cfg(2'd1, 1'b1, 8'hFF, 16'h0000, 1'b0);
    measure("R5", 1'b1, 12);
    set_cfg(2'd1, 1'b1, 8'hF0, 16'h0000, 1'b0);
    measure("R5", 1'b1, 192);
    count_ticks(1'b0, 100, c);
    check("R3", c, 0);
    set_cfg(2'd1, 1'b0, 8'hF0, 16'h0000, 1'b0);
    measure("R6", 1'b1, 384);
    set_cfg(2'd1, 1'b0, 8'h00, 16'h0000, 1'b0);
    measure("R6", 1'b1, 6144);
  endtask

  task automatic t_mode3();
    int c;
    set_cfg(2'd3, 1'b1, 8'hF8, 16'h0000, 1'b0);
    measure("R8", 1'b1, 96);
    set_cfg(2'd1, 1'b1, 8'hF8, 16'h0000, 1'b0);
    measure("R8", 1'b1, 96);
    set_cfg(2'd3, 1'b0, 8'hF8, 16'h0000, 1'b0);
    measure("R8", 1'b1, 192);
    count_ticks(1'b0, 100, c);
    check("R3", c, 0);
  endtask

  task automatic t_timer16();
    set_cfg(2'd1, 1'b0, 8'h00, 16'hFFFF, 1'b1);
    measure("R7", 1'b1, 2);
    set_cfg(2'd1, 1'b0, 8'h00, 16'hFF00, 1'b1);
    measure("R7", 1'b1, 512);
    set_cfg(2'd3, 1'b1, 8'h00, 16'hFF00, 1'b1);
    measure("R7", 1'b1, 512);
  endtask

  task automatic t_reload_change();
    int g;
    set_cfg(2'd1, 1'b1, 8'hF0, 16'h0000, 1'b0);
    measure("R9", 1'b1, 192);
    next_gap(1'b1, g);
    @(negedge clk);
    r8 = 8'hFA;
    measure("R9", 1'b1, 72);
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_mode2();
    t_timer8();
    t_mode3();
    t_timer16();
    t_reload_change();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule